// File: doc/BRIEF.md
# Dual-View Integer Register File

This block is the integer register store of a processor core. It holds 64 entries of 64 bits each and lets them be reached through two views. The wide view uses a 6-bit index and moves full 64-bit values. The narrow view uses a 4-bit index, so it reaches only the lowest 16 entries, and moves 32-bit values. Both views share the same storage. A narrow read hands back the low half of an entry with zeros above it. A narrow write fills the upper half with copies of the sign bit of the 32-bit value.

The highest entry, index 63, is a constant-zero register in the wide view. Reading it always gives zero, and writing to it changes nothing. Each view has two combinational read ports and one write port. Writes take effect on the rising clock edge. A read in the same cycle as a write to that entry still shows the old contents; forwarding belongs to the surrounding pipeline. If both views write the same entry in one cycle, the wide-view write wins.

Top module: `dual_view_regfile`

## Requirements
- R1: A wide-view write with `wd_we`=1 to index 0..62 is visible on either wide read port from the cycle after the rising edge that takes it.
- R2: A wide read of index 63 returns 64'h0 at all times.
- R3: A wide write to index 63 is dropped and leaves every other entry unchanged.
- R4: A narrow index k (0..15) addresses the same entry as wide index k; a narrow write to entry 15 leaves entry 16 untouched.
- R5: A narrow read returns bits [31:0] of the addressed entry in bits [31:0], with bits [63:32] equal to zero.
- R6: A narrow write stores the 32-bit value with bit 31 copied into bits [63:32].
- R7: Read ports are combinational and, in the cycle of a write to the same entry, return the value held before that write.
- R8: A rising clock edge with `rst_n`=0 clears every entry to zero. Reset overrides any write in that cycle.
- R9: When both views write the same entry in one cycle, the entry takes the wide-view data. When they write different entries, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wd_we | input | 1 | Wide-view write enable |
| wd_waddr | input | 6 | Wide-view write index |
| wd_wdata | input | 64 | Wide-view write data |
| nw_we | input | 1 | Narrow-view write enable |
| nw_waddr | input | 4 | Narrow-view write index |
| nw_wdata | input | 32 | Narrow-view write data |
| wd_raddr_a | input | 6 | Wide read port A index |
| wd_rdata_a | output | 64 | Wide read port A data |
| wd_raddr_b | input | 6 | Wide read port B index |
| wd_rdata_b | output | 64 | Wide read port B data |
| nw_raddr_a | input | 4 | Narrow read port A index |
| nw_rdata_a | output | 64 | Narrow read port A data, zero-extended |
| nw_raddr_b | input | 4 | Narrow read port B index |
| nw_rdata_b | output | 64 | Narrow read port B data, zero-extended |

## Verification
The bench builds the block with its default parameters: 64 entries of 64 bits, with a 16-entry, 32-bit narrow view. With these values the constant-zero entry sits at index 63, which the narrow index cannot reach. The full sweep of narrow indices therefore ends at entry 15, next to entry 16, which the narrow view must never touch. Sign extension is exercised with data whose bit 31 is set and with data whose bit 31 is clear.

// File: rtl/rf_pkg.sv
// Package: shared definitions for the dual-view register file.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package rf_pkg;
    // Selects which access view a read mux implements.
    typedef enum logic {
        VIEW_WIDE   = 1'b0,
        VIEW_NARROW = 1'b1
    } rf_view_e;
endpackage

// File: rtl/rf_wr_decode.sv
// Module: rf_wr_decode
// Turns the wide and narrow write requests into one select vector per view.
// Writes to the constant-zero entry are removed here, so that entry is never
// written. Where both views aim at the same entry, the narrow select is
// suppressed so the wide write wins.
// Assumes: NARROW_REGS <= NUM_REGS, and both are powers of two.
module rf_wr_decode #(
    parameter int NUM_REGS    = 64,
    parameter int NARROW_REGS = 16,
    parameter int ZERO_IDX    = NUM_REGS - 1,
    localparam int AW         = $clog2(NUM_REGS),
    localparam int NAW        = $clog2(NARROW_REGS)
) (
    input  logic                wide_en,
    input  logic [AW-1:0]       wide_idx,
    input  logic                nar_en,
    input  logic [NAW-1:0]      nar_idx,
    output logic [NUM_REGS-1:0] sel_wide,
    output logic [NUM_REGS-1:0] sel_nar
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        if (i == ZERO_IDX) begin : g_zero
            // Constant-zero entry: never selected by either view.
            assign sel_wide[i] = 1'b0;
            assign sel_nar[i]  = 1'b0;
        end else if (i < NARROW_REGS) begin : g_both
            // Entry reachable from both views; wide takes priority.
            assign sel_wide[i] = wide_en && (wide_idx == AW'(i));
            assign sel_nar[i]  = nar_en && (nar_idx == NAW'(i))
                                 && !(wide_en && (wide_idx == AW'(i)));
        end else begin : g_wide_only
            // Entry outside the narrow window.
            assign sel_wide[i] = wide_en && (wide_idx == AW'(i));
            assign sel_nar[i]  = 1'b0;
        end
    end
endmodule

// File: rtl/rf_storage.sv
// Module: rf_storage
// One flop row per entry, each with its own write select. The wide data goes
// to an entry whose wide select is set. Otherwise the sign-extended narrow
// data goes to it if its narrow select is set.
// Assumes: at most one select per entry is set in a cycle (rf_wr_decode
// guarantees this). The reset is synchronous and active low.
module rf_storage #(
    parameter int NUM_REGS = 64,
    parameter int XLEN     = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] sel_wide,
    input  logic [NUM_REGS-1:0] sel_nar,
    input  logic [XLEN-1:0]     wide_data,
    input  logic [XLEN-1:0]     nar_data,
    output logic [XLEN-1:0]     regs [NUM_REGS]
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_row
        // Entry update: reset clears it, wide write first, then narrow write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (sel_wide[i]) begin
                regs[i] <= wide_data;
            end else if (sel_nar[i]) begin
                regs[i] <= nar_data;
            end
        end
    end
endmodule

// File: rtl/rf_read_mux.sv
// Module: rf_read_mux
// One combinational read port. The VIEW parameter picks the variant.
// The wide variant returns the full entry, or zero for the constant-zero index.
// The narrow variant returns the low NARROW_W bits with zeros above them.
// Assumes: IDX_W <= log2(NUM_REGS). A narrow index is zero-extended.
module rf_read_mux #(
    parameter int               NUM_REGS = 64,
    parameter int               XLEN     = 64,
    parameter int               NARROW_W = 32,
    parameter int               IDX_W    = 6,
    parameter int               ZERO_IDX = NUM_REGS - 1,
    parameter rf_pkg::rf_view_e VIEW     = rf_pkg::VIEW_WIDE,
    localparam int              AW       = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  regs [NUM_REGS],
    output logic [XLEN-1:0]  data
);
    logic [AW-1:0]   full_idx;
    logic [XLEN-1:0] picked;

    assign full_idx = AW'(idx);
    assign picked   = regs[full_idx];

    if (VIEW == rf_pkg::VIEW_WIDE) begin : g_wide
        // Wide read: force zero on the constant-zero index.
        always_comb begin
            data = (full_idx == AW'(ZERO_IDX)) ? '0 : picked;
        end
    end else begin : g_narrow
        localparam logic [XLEN-1:0] LOW_MASK =
            {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        // Narrow read: keep the low half, clear the upper bits.
        always_comb begin
            data = picked & LOW_MASK;
        end
    end
endmodule

// File: rtl/dual_view_regfile.sv
// Module: dual_view_regfile (top)
// Register file with NUM_REGS entries of XLEN bits, reachable through a wide
// view and a narrow view. Each view has RD_PORTS combinational read ports and
// one write port. The narrow view reaches entries below NARROW_REGS, reads
// them zero-extended and writes them sign-extended. The top entry reads as
// zero in the wide view and never takes a write.
// Assumes: a synchronous active-low reset. Forwarding is done outside.
module dual_view_regfile #(
    parameter int  NUM_REGS    = 64,
    parameter int  XLEN        = 64,
    parameter int  NARROW_REGS = 16,
    parameter int  NARROW_W    = 32,
    localparam int AW          = $clog2(NUM_REGS),
    localparam int NAW         = $clog2(NARROW_REGS),
    localparam int ZERO_IDX    = NUM_REGS - 1,
    localparam int RD_PORTS    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wd_we,
    input  logic [AW-1:0]   wd_waddr,
    input  logic [XLEN-1:0] wd_wdata,
    input  logic            nw_we,
    input  logic [NAW-1:0]  nw_waddr,
    input  logic [NARROW_W-1:0] nw_wdata,
    input  logic [AW-1:0]   wd_raddr_a,
    output logic [XLEN-1:0] wd_rdata_a,
    input  logic [AW-1:0]   wd_raddr_b,
    output logic [XLEN-1:0] wd_rdata_b,
    input  logic [NAW-1:0]  nw_raddr_a,
    output logic [XLEN-1:0] nw_rdata_a,
    input  logic [NAW-1:0]  nw_raddr_b,
    output logic [XLEN-1:0] nw_rdata_b
);
    logic [NUM_REGS-1:0] sel_wide;
    logic [NUM_REGS-1:0] sel_nar;
    logic [XLEN-1:0]     nar_ext;
    logic [XLEN-1:0]     regs [NUM_REGS];
    logic [AW-1:0]       wd_ra [RD_PORTS];
    logic [NAW-1:0]      nw_ra [RD_PORTS];
    logic [XLEN-1:0]     wd_rd [RD_PORTS];
    logic [XLEN-1:0]     nw_rd [RD_PORTS];

    // Sign-extend the narrow write data to the full entry width.
    assign nar_ext = {{(XLEN-NARROW_W){nw_wdata[NARROW_W-1]}}, nw_wdata};

    // Gather the read-port indices and results into arrays.
    assign wd_ra[0]   = wd_raddr_a;
    assign wd_ra[1]   = wd_raddr_b;
    assign nw_ra[0]   = nw_raddr_a;
    assign nw_ra[1]   = nw_raddr_b;
    assign wd_rdata_a = wd_rd[0];
    assign wd_rdata_b = wd_rd[1];
    assign nw_rdata_a = nw_rd[0];
    assign nw_rdata_b = nw_rd[1];

    rf_wr_decode #(
        .NUM_REGS    (NUM_REGS),
        .NARROW_REGS (NARROW_REGS),
        .ZERO_IDX    (ZERO_IDX)
    ) u_dec (
        .wide_en  (wd_we),
        .wide_idx (wd_waddr),
        .nar_en   (nw_we),
        .nar_idx  (nw_waddr),
        .sel_wide (sel_wide),
        .sel_nar  (sel_nar)
    );

    rf_storage #(
        .NUM_REGS (NUM_REGS),
        .XLEN     (XLEN)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wide  (sel_wide),
        .sel_nar   (sel_nar),
        .wide_data (wd_wdata),
        .nar_data  (nar_ext),
        .regs      (regs)
    );

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rport
        rf_read_mux #(
            .NUM_REGS (NUM_REGS),
            .XLEN     (XLEN),
            .NARROW_W (NARROW_W),
            .IDX_W    (AW),
            .ZERO_IDX (ZERO_IDX),
            .VIEW     (rf_pkg::VIEW_WIDE)
        ) u_wide_rd (
            .idx  (wd_ra[p]),
            .regs (regs),
            .data (wd_rd[p])
        );

        rf_read_mux #(
            .NUM_REGS (NUM_REGS),
            .XLEN     (XLEN),
            .NARROW_W (NARROW_W),
            .IDX_W    (NAW),
            .ZERO_IDX (ZERO_IDX),
            .VIEW     (rf_pkg::VIEW_NARROW)
        ) u_nar_rd (
            .idx  (nw_ra[p]),
            .regs (regs),
            .data (nw_rd[p])
        );
    end
endmodule

// File: rtl/rf_checker.sv
// Module: rf_checker
// Port-level properties for dual_view_regfile. It is attached with the bind
// statement at the end of this file.
// Assumes: the same parameter values as the bound instance.
module rf_checker #(
    parameter int  NUM_REGS    = 64,
    parameter int  XLEN        = 64,
    parameter int  NARROW_REGS = 16,
    parameter int  NARROW_W    = 32,
    localparam int AW          = $clog2(NUM_REGS),
    localparam int NAW         = $clog2(NARROW_REGS),
    localparam int ZERO_IDX    = NUM_REGS - 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wd_we,
    input logic [AW-1:0]        wd_waddr,
    input logic [XLEN-1:0]      wd_wdata,
    input logic                 nw_we,
    input logic [NAW-1:0]       nw_waddr,
    input logic [NARROW_W-1:0]  nw_wdata,
    input logic [AW-1:0]        wd_raddr_a,
    input logic [XLEN-1:0]      wd_rdata_a,
    input logic [AW-1:0]        wd_raddr_b,
    input logic [XLEN-1:0]      wd_rdata_b,
    input logic [XLEN-NARROW_W-1:0] nar_hi
);
    AST_ZERO_ENTRY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_raddr_a == AW'(ZERO_IDX)) |-> (wd_rdata_a == '0)); // R2

    AST_WIDE_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_we && (wd_waddr != AW'(ZERO_IDX))) ##1 (wd_raddr_a == $past(wd_waddr))
        |-> (wd_rdata_a == $past(wd_wdata))); // R1

    AST_NARROW_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (nw_we && !(wd_we && (wd_waddr == AW'(nw_waddr))))
        ##1 (wd_raddr_b == AW'($past(nw_waddr)))
        |-> (wd_rdata_b == {{(XLEN-NARROW_W){$past(nw_wdata[NARROW_W-1])}},
                            $past(nw_wdata)})); // R6

    AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        nar_hi == '0); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk)
        (!rst_n) |=> (wd_rdata_a == '0)); // R8
endmodule

bind dual_view_regfile rf_checker #(
    .NUM_REGS    (NUM_REGS),
    .XLEN        (XLEN),
    .NARROW_REGS (NARROW_REGS),
    .NARROW_W    (NARROW_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wd_we      (wd_we),
    .wd_waddr   (wd_waddr),
    .wd_wdata   (wd_wdata),
    .nw_we      (nw_we),
    .nw_waddr   (nw_waddr),
    .nw_wdata   (nw_wdata),
    .wd_raddr_a (wd_raddr_a),
    .wd_rdata_a (wd_rdata_a),
    .wd_raddr_b (wd_raddr_b),
    .wd_rdata_b (wd_rdata_b),
    .nar_hi     (nw_rdata_a[XLEN-1:NARROW_W])
);

// File: tb/sim_dual_view_regfile.sv
`timescale 1ns/1ps
// Directed bench for dual_view_regfile. Each task is one scenario and checks
// its own results against a behavioural model kept in the bench.
module sim_dual_view_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wd_we = 1'b0;
    logic [5:0]  wd_waddr = '0;
    logic [63:0] wd_wdata = '0;
    logic        nw_we = 1'b0;
    logic [3:0]  nw_waddr = '0;
    logic [31:0] nw_wdata = '0;
    logic [5:0]  wd_raddr_a = '0;
    logic [5:0]  wd_raddr_b = '0;
    logic [3:0]  nw_raddr_a = '0;
    logic [3:0]  nw_raddr_b = '0;
    logic [63:0] wd_rdata_a, wd_rdata_b, nw_rdata_a, nw_rdata_b;

    logic [63:0] model [64];
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_view_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .wd_we(wd_we), .wd_waddr(wd_waddr), .wd_wdata(wd_wdata),
        .nw_we(nw_we), .nw_waddr(nw_waddr), .nw_wdata(nw_wdata),
        .wd_raddr_a(wd_raddr_a), .wd_rdata_a(wd_rdata_a),
        .wd_raddr_b(wd_raddr_b), .wd_rdata_b(wd_rdata_b),
        .nw_raddr_a(nw_raddr_a), .nw_rdata_a(nw_rdata_a),
        .nw_raddr_b(nw_raddr_b), .nw_rdata_b(nw_rdata_b)
    );

    function automatic logic [63:0] pat(int i);
        return {8'(i), 8'hA5, 16'(i * 257), 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101)};
    endfunction

    function automatic logic [63:0] exp_wide(int i);
        return (i == 63) ? 64'h0 : model[i];
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one write cycle on either or both views and update the model.
    task automatic wr(logic we, int wa, logic [63:0] wdat, logic ne, int na, logic [31:0] ndat);
        @(negedge clk);
        wd_we = we; wd_waddr = 6'(wa); wd_wdata = wdat;
        nw_we = ne; nw_waddr = 4'(na); nw_wdata = ndat;
        @(posedge clk);
        if (ne && !(we && wa == na)) model[na] = {{32{ndat[31]}}, ndat};
        if (we && wa != 63) model[wa] = wdat;
        @(negedge clk);
        wd_we = 1'b0; nw_we = 1'b0;
    endtask

    // Read entry i on both wide ports, and on both narrow ports when in range.
    task automatic rd_all(string req, int i);
        @(negedge clk);
        wd_raddr_a = 6'(i); wd_raddr_b = 6'(i);
        if (i < 16) begin nw_raddr_a = 4'(i); nw_raddr_b = 4'(i); end
        #1;
        chk(req, wd_rdata_a, exp_wide(i));
        chk(req, wd_rdata_b, exp_wide(i));
        if (i < 16) begin
            chk(req, nw_rdata_a, {32'h0, model[i][31:0]});
            chk(req, nw_rdata_b, {32'h0, model[i][31:0]});
        end
    endtask

    // R8: reset while a write is requested; every entry must read zero.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; wd_we = 1'b1; wd_waddr = 6'd4; wd_wdata = 64'hFFFF_0000_FFFF_0000;
        nw_we = 1'b1; nw_waddr = 4'd2; nw_wdata = 32'hFFFF_FFFF;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 64; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1'b1; wd_we = 1'b0; nw_we = 1'b0;
        for (int i = 0; i < 64; i++) rd_all("R8 reset clears entry", i);
    endtask

    // R1: fill every wide entry with a distinct pattern and read it back.
    task automatic t_wide_fill();
        for (int i = 0; i < 63; i++) wr(1'b1, i, pat(i), 1'b0, 0, 32'h0);
        for (int i = 0; i < 63; i++) rd_all("R1 wide write/read", i);
    endtask

    // R2, R3: write entry 63; it reads zero and no other entry moves.
    task automatic t_zero_entry();
        wr(1'b1, 63, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, 32'h0);
        rd_all("R2 zero entry reads zero", 63);
        for (int i = 0; i < 63; i++) rd_all("R3 zero-entry write disturbs nothing", i);
    endtask

    // R5: narrow read of a value with both halves populated.
    task automatic t_narrow_read();
        wr(1'b1, 3, 64'hDEAD_BEEF_8000_0001, 1'b0, 0, 32'h0);
        @(negedge clk);
        nw_raddr_a = 4'd3; nw_raddr_b = 4'd3;
        #1;
        chk("R5 narrow read zero-extends", nw_rdata_a, 64'h0000_0000_8000_0001);
        chk("R5 narrow read zero-extends", nw_rdata_b, 64'h0000_0000_8000_0001);
    endtask

    // R4, R6: narrow writes with bit 31 set and clear, including entry 15.
    task automatic t_narrow_write();
        wr(1'b0, 0, 64'h0, 1'b1, 7, 32'h8000_0000);
        @(negedge clk); wd_raddr_a = 6'd7; #1;
        chk("R6 negative sign extension", wd_rdata_a, 64'hFFFF_FFFF_8000_0000);
        wr(1'b0, 0, 64'h0, 1'b1, 7, 32'h7FFF_FFFF);
        @(negedge clk); wd_raddr_a = 6'd7; #1;
        chk("R6 positive sign extension", wd_rdata_a, 64'h0000_0000_7FFF_FFFF);
        wr(1'b0, 0, 64'h0, 1'b1, 15, 32'hFFFF_FFFE);
        @(negedge clk); wd_raddr_a = 6'd15; wd_raddr_b = 6'd16; #1;
        chk("R4 narrow index 15 maps to entry 15", wd_rdata_a, 64'hFFFF_FFFF_FFFF_FFFE);
        chk("R4 entry 16 untouched", wd_rdata_b, pat(16));
        for (int i = 0; i < 16; i++) rd_all("R4 narrow/wide alias", i);
    endtask

    // R7: read and write the same entry in one cycle.
    task automatic t_read_during_write();
        logic [63:0] old_v;
        old_v = model[9];
        @(negedge clk);
        wd_we = 1'b1; wd_waddr = 6'd9; wd_wdata = 64'h0123_4567_89AB_CDEF;
        wd_raddr_a = 6'd9; nw_raddr_a = 4'd9;
        #1;
        chk("R7 wide read returns old value", wd_rdata_a, old_v);
        chk("R7 narrow read returns old value", nw_rdata_a, {32'h0, old_v[31:0]});
        @(posedge clk);
        model[9] = 64'h0123_4567_89AB_CDEF;
        @(negedge clk);
        wd_we = 1'b0;
        #1;
        chk("R7 new value after edge", wd_rdata_a, 64'h0123_4567_89AB_CDEF);
    endtask

    // R9: both views write together, same entry and different entries.
    task automatic t_collision();
        wr(1'b1, 5, 64'hAAAA_5555_CCCC_3333, 1'b1, 5, 32'h8000_0000);
        @(negedge clk); wd_raddr_a = 6'd5; #1;
        chk("R9 wide wins on same entry", wd_rdata_a, 64'hAAAA_5555_CCCC_3333);
        wr(1'b1, 20, 64'h1111_2222_3333_4444, 1'b1, 2, 32'h0000_1234);
        @(negedge clk); wd_raddr_a = 6'd20; wd_raddr_b = 6'd2; #1;
        chk("R9 wide lands on distinct entry", wd_rdata_a, 64'h1111_2222_3333_4444);
        chk("R9 narrow lands on distinct entry", wd_rdata_b, 64'h0000_0000_0000_1234);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = '0;
        t_reset();
        t_wide_fill();
        t_zero_entry();
        t_narrow_read();
        t_narrow_write();
        t_read_during_write();
        t_collision();
        t_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule